// File: doc/BRIEF.md
# Motor PWM Control Register Logic

This block holds the main control and status byte of a motor-control PWM peripheral. Software reaches it through a single-address bus port that has separate read and write strobes. The PWM timebase feeds it two one-cycle strobes: one marks the start of a reload cycle and the other marks the start of each PWM cycle. A separate write-once port loads a disable mapping. For each of two output banks, the mapping selects which pins a software disable forces to their inactive state.

Setting a bank's disable bit takes effect on the next clock. Clearing the bit lifts the disable only at the next PWM cycle start, so a half-finished pulse cannot reappear in the middle of a period. The reload flag is set by hardware on every reload. Software clears it with a handshake: a read that sees the flag set, then a write of zero to the flag bit. A reload that lands between the read and the write breaks the handshake. The interrupt request is the flag gated by the interrupt enable bit.

Top module: `pwmctl_regs`

## Requirements
- R1: After reset, the register reads 0x00, both bank masks are 0, the mapping is 0 and `irq` is low.
- R2: A write loads bit 7 (bank X disable), bit 6 (bank Y disable), bit 5 (interrupt enable), bits 3:2 (sense select), bit 1 (load-ok) and bit 0 (PWM enable). Reads return them in the same positions, with the reload flag at bit 4. `sense_sel`, `load_ok` and `pwm_en` follow bits 3:2, 1 and 0.
- R3: In the cycle after a write sets a bank's disable bit, that bank's mask equals that bank's mapping bits.
- R4: After a write clears a bank's disable bit, the bank's mask holds. It drops to 0 after the first PWM cycle start strobe that arrives in a later cycle than the clearing write.
- R5: Only the first mapping write after reset is taken: bits 2:0 map bank X and bits 5:3 map bank Y. Later mapping writes are ignored until the next reset.
- R6: A reload strobe sets the reload flag whether or not load-ok is set.
- R7: The reload flag clears only on a write with bit 4 = 0 that follows a read which saw the flag set. A zero write without such a read leaves the flag set.
- R8: A reload strobe that comes after the arming read cancels the arming, so a later zero write does not clear the flag. A reload in the same cycle as the clearing write also wins, and the flag stays set.
- R9: Writing 1 to bit 4 never sets the reload flag.
- R10: `irq` is high exactly while the reload flag and the interrupt enable are both set. Clearing either one withdraws the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| map_wr | input | 1 | Disable mapping write strobe |
| map_wdata | input | 2*PINS_PER_BANK | Mapping data, bank X in the low bits |
| reload_stb | input | 1 | Reload cycle start strobe |
| cycle_stb | input | 1 | PWM cycle start strobe |
| dis_mask_x | output | PINS_PER_BANK | Pins of bank X forced inactive |
| dis_mask_y | output | PINS_PER_BANK | Pins of bank Y forced inactive |
| irq | output | 1 | Reload interrupt request |
| load_ok | output | 1 | Load-ok bit |
| pwm_en | output | 1 | PWM enable bit |
| sense_sel | output | 2 | Sense select bits |

## Verification
The bench builds the block with its default of three pins per bank. With that setting, mapping patterns that differ between the two banks and within a bank can be written and told apart on the masks. The stimulus times the clearing write, the PWM cycle start strobe and the reload strobe so that they land in the same cycle or in adjacent cycles. This reaches the cases where a bank re-enable is deferred once more, where an arming read is cancelled, and where a reload wins the same-cycle race.

// File: rtl/pwmctl_pkg.sv
package pwmctl_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_DISX   = 7;
  localparam int BIT_DISY   = 6;
  localparam int BIT_IEN    = 5;
  localparam int BIT_FLAG   = 4;
  localparam int BIT_SNS_HI = 3;
  localparam int BIT_SNS_LO = 2;
  localparam int BIT_LDOK   = 1;
  localparam int BIT_EN     = 0;
  localparam int NUM_BANKS  = 2;

  // Next value of the reload flag: hardware set beats a software clear.
  function automatic logic flag_next(input logic flag, input logic armed,
                                     input logic reload, input logic clr_wr);
    if (reload)              return 1'b1;
    else if (clr_wr && armed) return 1'b0;
    else                     return flag;
  endfunction

  // Next value of a bank's active disable: a set is immediate, a release waits
  // for a cycle start seen while the software bit is already clear.
  function automatic logic dis_next(input logic act, input logic set_now,
                                    input logic sw_q, input logic cyc);
    if (set_now)          return 1'b1;
    else if (cyc && !sw_q) return 1'b0;
    else                  return act;
  endfunction
endpackage

// File: rtl/pwmctl_map.sv
module pwmctl_map #(
  parameter int MAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_wr,
  input  logic [MAP_W-1:0] map_wdata,
  output logic [MAP_W-1:0] map_q
);
  logic locked_q;
  logic take_wr;

  assign take_wr = map_wr && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q    <= '0;
      locked_q <= 1'b0;
    end else if (take_wr) begin
      map_q    <= map_wdata;
      locked_q <= 1'b1;
    end
  end

  AST_MAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(map_q)); // R5
endmodule

// File: rtl/pwmctl_bank.sv
module pwmctl_bank #(
  parameter int PINS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wbit,
  input  logic            cycle_stb,
  input  logic [PINS-1:0] map_bits,
  output logic            sw_q,
  output logic [PINS-1:0] mask
);
  import pwmctl_pkg::*;

  logic act_q;
  logic set_evt;
  logic release_evt;

  assign set_evt     = wr_en && wbit;
  assign release_evt = cycle_stb && !sw_q && !set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (wr_en) sw_q <= wbit;
      act_q <= dis_next(act_q, set_evt, sw_q, cycle_stb);
    end
  end

  assign mask = {PINS{act_q}} & map_bits;

  AST_SET_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> act_q); // R3
  AST_REENABLE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(release_evt)); // R4
endmodule

// File: rtl/pwmctl_flag.sv
module pwmctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wbit,
  input  logic reload_stb,
  output logic flag_q
);
  import pwmctl_pkg::*;

  logic armed_q;
  logic clr_wr;
  logic clr_ok;

  assign clr_wr = wr_en && !wbit;
  assign clr_ok = clr_wr && armed_q && !reload_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, armed_q, reload_stb, clr_wr);
      if (reload_stb || clr_ok) armed_q <= 1'b0;
      else if (rd_en && flag_q) armed_q <= 1'b1;
    end
  end

  AST_FLAG_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |=> flag_q); // R6
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q) && $past(clr_wr)); // R7
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !reload_stb) |=> !flag_q); // R9
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_stb && clr_wr) |=> flag_q && !armed_q); // R8
endmodule

// File: rtl/pwmctl_regs.sv
module pwmctl_regs #(
  parameter int PINS_PER_BANK = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic                       map_wr,
  input  logic [2*PINS_PER_BANK-1:0] map_wdata,
  input  logic                       reload_stb,
  input  logic                       cycle_stb,
  output logic [PINS_PER_BANK-1:0]   dis_mask_x,
  output logic [PINS_PER_BANK-1:0]   dis_mask_y,
  output logic                       irq,
  output logic                       load_ok,
  output logic                       pwm_en,
  output logic [1:0]                 sense_sel
);
  import pwmctl_pkg::*;

  localparam int MAP_W = NUM_BANKS * PINS_PER_BANK;

  logic [MAP_W-1:0]         map_q;
  logic                     ien_q;
  logic                     ldok_q;
  logic                     en_q;
  logic [1:0]               sns_q;
  logic                     flag_q;
  logic [NUM_BANKS-1:0]     sw_dis;
  logic [PINS_PER_BANK-1:0] bank_mask [NUM_BANKS];

  pwmctl_map #(.MAP_W(MAP_W)) u_map (
    .clk(clk), .rst_n(rst_n), .map_wr(map_wr),
    .map_wdata(map_wdata), .map_q(map_q)
  );

  // Bank 0 is X (bit 7), bank 1 is Y (bit 6).
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pwmctl_bank #(.PINS(PINS_PER_BANK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr),
      .wbit(reg_wdata[BIT_DISX-b]), .cycle_stb(cycle_stb),
      .map_bits(map_q[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .sw_q(sw_dis[b]), .mask(bank_mask[b])
    );
  end

  pwmctl_flag u_flag (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .wr_en(reg_wr),
    .wbit(reg_wdata[BIT_FLAG]), .reload_stb(reload_stb), .flag_q(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      ldok_q <= 1'b0;
      en_q   <= 1'b0;
      sns_q  <= 2'b00;
    end else if (reg_wr) begin
      ien_q  <= reg_wdata[BIT_IEN];
      ldok_q <= reg_wdata[BIT_LDOK];
      en_q   <= reg_wdata[BIT_EN];
      sns_q  <= reg_wdata[BIT_SNS_HI:BIT_SNS_LO];
    end
  end

  always_comb begin
    reg_rdata                        = '0;
    reg_rdata[BIT_DISX]              = sw_dis[0];
    reg_rdata[BIT_DISY]              = sw_dis[1];
    reg_rdata[BIT_IEN]               = ien_q;
    reg_rdata[BIT_FLAG]              = flag_q;
    reg_rdata[BIT_SNS_HI:BIT_SNS_LO] = sns_q;
    reg_rdata[BIT_LDOK]              = ldok_q;
    reg_rdata[BIT_EN]                = en_q;
  end

  assign dis_mask_x = bank_mask[0];
  assign dis_mask_y = bank_mask[1];
  assign irq        = flag_q && ien_q;
  assign load_ok    = ldok_q;
  assign pwm_en     = en_q;
  assign sense_sel  = sns_q;

  AST_IEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[BIT_IEN]) |=> !irq); // R10
endmodule

// File: tb/tb_pwmctl_regs.sv
module tb_pwmctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       map_wr = 1'b0;
  logic [5:0] map_wdata = '0;
  logic       reload_stb = 1'b0, cycle_stb = 1'b0;
  logic [2:0] dis_mask_x, dis_mask_y;
  logic       irq, load_ok, pwm_en;
  logic [1:0] sense_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwmctl_regs #(.PINS_PER_BANK(3)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .map_wr(map_wr),
    .map_wdata(map_wdata), .reload_stb(reload_stb), .cycle_stb(cycle_stb),
    .dis_mask_x(dis_mask_x), .dis_mask_y(dis_mask_y), .irq(irq),
    .load_ok(load_ok), .pwm_en(pwm_en), .sense_sel(sense_sel)
  );

  // op: 0 idle, 1 register write, 2 register read, 3 mapping write
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic       rel;
    logic       cyc;
    logic [7:0] e_rd;
    logic [2:0] e_mx;
    logic [2:0] e_my;
    logic       e_irq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{2'd3, 8'h2B, 1'b0, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 4'd5},  // R5 map X=011 Y=101
    '{2'd3, 8'h3F, 1'b0, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 4'd5},  // R5 second map ignored
    '{2'd1, 8'h80, 1'b0, 1'b0, 8'h80, 3'b011, 3'b000, 1'b0, 4'd3},  // R3 bank X on
    '{2'd1, 8'h40, 1'b0, 1'b0, 8'h40, 3'b011, 3'b101, 1'b0, 4'd4},  // R4 X held, R3 Y on
    '{2'd0, 8'h00, 1'b0, 1'b1, 8'h40, 3'b000, 3'b101, 1'b0, 4'd4},  // R4 X released
    '{2'd1, 8'h00, 1'b0, 1'b1, 8'h00, 3'b000, 3'b101, 1'b0, 4'd4},  // R4 same-cycle start: held
    '{2'd0, 8'h00, 1'b0, 1'b1, 8'h00, 3'b000, 3'b000, 1'b0, 4'd4},  // R4 Y released
    '{2'd1, 8'h2F, 1'b0, 1'b0, 8'h2F, 3'b000, 3'b000, 1'b0, 4'd2},  // R2
    '{2'd0, 8'h00, 1'b1, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd6},  // R6
    '{2'd1, 8'h2F, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd7},  // R7 no read: stays
    '{2'd2, 8'h00, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd7},  // R7 arm
    '{2'd1, 8'h2F, 1'b0, 1'b0, 8'h2F, 3'b000, 3'b000, 1'b0, 4'd7},  // R7 cleared, R10
    '{2'd0, 8'h00, 1'b1, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd6},  // R6
    '{2'd2, 8'h00, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 arm
    '{2'd0, 8'h00, 1'b1, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 reload breaks
    '{2'd1, 8'h2F, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 no clear
    '{2'd2, 8'h00, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 arm
    '{2'd1, 8'h2F, 1'b1, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 same-cycle reload wins
    '{2'd1, 8'h2F, 1'b0, 1'b0, 8'h3F, 3'b000, 3'b000, 1'b1, 4'd8},  // R8 arming cancelled
    '{2'd1, 8'h0F, 1'b0, 1'b0, 8'h1F, 3'b000, 3'b000, 1'b0, 4'd10}, // R10 ien off
    '{2'd2, 8'h00, 1'b0, 1'b0, 8'h1F, 3'b000, 3'b000, 1'b0, 4'd7},  // R7 arm
    '{2'd1, 8'h20, 1'b0, 1'b0, 8'h20, 3'b000, 3'b000, 1'b0, 4'd10}, // R10 flag clear
    '{2'd1, 8'h30, 1'b0, 1'b0, 8'h20, 3'b000, 3'b000, 1'b0, 4'd9},  // R9 write 1 no set
    '{2'd0, 8'h00, 1'b1, 1'b0, 8'h30, 3'b000, 3'b000, 1'b1, 4'd6},  // R6 ldok clear
    '{2'd2, 8'h00, 1'b0, 1'b0, 8'h30, 3'b000, 3'b000, 1'b1, 4'd7},  // R7 arm
    '{2'd1, 8'h00, 1'b0, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 4'd7}   // R7 clear
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    reg_wr     = (v.op == 2'd1);
    reg_rd     = (v.op == 2'd2);
    map_wr     = (v.op == 2'd3);
    reg_wdata  = v.data;
    map_wdata  = v.data[5:0];
    reload_stb = v.rel;
    cycle_stb  = v.cyc;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0; map_wr = 1'b0;
    reload_stb = 1'b0; cycle_stb = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {reg_rdata, dis_mask_x, dis_mask_y, irq, load_ok, pwm_en, sense_sel},
          {8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vec%0d", TBL[i].req, i),
            {reg_rdata, dis_mask_x, dis_mask_y, irq},
            {TBL[i].e_rd, TBL[i].e_mx, TBL[i].e_my, TBL[i].e_irq});
    end
    // R2 output pins follow their bits
    apply('{2'd1, 8'h09, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd2});
    check("R2 pins", {sense_sel, load_ok, pwm_en}, {2'b10, 1'b0, 1'b1});
    apply('{2'd1, 8'h06, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd2});
    check("R2 pins", {sense_sel, load_ok, pwm_en}, {2'b01, 1'b1, 1'b0});
    // R1 reset again, then R5 mapping writable once more
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 rereset", {reg_rdata, irq, load_ok, pwm_en, sense_sel},
          {8'h00, 1'b0, 1'b0, 1'b0, 2'b00});
    rst_n = 1'b1;
    apply('{2'd3, 8'h1C, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd5});
    apply('{2'd3, 8'h07, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd5});
    apply('{2'd1, 8'hC0, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd3});
    check("R5 R3 map after reset", {dis_mask_x, dis_mask_y}, {3'b100, 3'b011});
    // R4 release of both banks needs a later cycle start
    apply('{2'd1, 8'h00, 1'b0, 1'b0, 8'h0, 3'b0, 3'b0, 1'b0, 4'd4});
    check("R4 hold", {dis_mask_x, dis_mask_y}, {3'b100, 3'b011});
    apply('{2'd0, 8'h00, 1'b0, 1'b1, 8'h0, 3'b0, 3'b0, 1'b0, 4'd4});
    check("R4 release", {dis_mask_x, dis_mask_y}, {3'b000, 3'b000});
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule